// File: doc/BRIEF.md
# Rotating-Enable Pipeline

This block is a fixed-depth data pipeline in which every stage register carries its own clock enable. The enables are not derived from per-stage handshakes. They come from a ring shift register that holds one bit per stage and rotates by one position on every edge of the pipeline clock. Stage `i` advances only when ring bit `i` is set. In every other cycle the stage keeps both its data and its valid flag unchanged. Gating is modelled only as flip-flop enables, and the clock keeps running.

The ring pattern sets the throughput. In full-rate mode every ring bit is one, so the block behaves as an ordinary pipeline that accepts a word on every cycle. In half-rate mode the ring holds alternating ones and zeros. A word enters only on every second cycle and then moves one stage per cycle. The rate select is sampled once, on the first clock edge after reset is released, and is locked until the next reset.

Each stage adds its own constant (`STEP * (i+1)` for stage `i`), so the output word is the input word plus a known sum. This lets a user check the results end to end.

Top module: `rot_en_pipe`

## Requirements
- R1: The ring holds STAGES bits and rotates one position per clock (bit i+1 takes bit i, and bit 0 takes the top bit). Stage i is enabled only by ring bit i. After loading, the ring always holds STAGES set bits in full-rate mode and STAGES/2 set bits in half-rate mode.
- R2: In full-rate mode (`half_rate_i`=0 at load) a word offered with `in_valid_i`=1 is accepted on every edge from the second edge after reset release onward. Each accepted word appears on the output with `out_valid_o`=1 exactly STAGES-1 edges after the edge that accepted it, and back-to-back inputs give back-to-back outputs.
- R3: In half-rate mode (`half_rate_i`=1 at load) input is accepted only on the 2nd, 4th, 6th, ... edges after reset release. A word offered on any other edge is dropped and never reaches the output.
- R4: In half-rate mode `out_valid_o` is never high on two consecutive cycles.
- R5: A stage whose enable bit is clear keeps its data and valid registers unchanged. Between two half-rate outputs, `out_data_o` holds the last output word.
- R6: The rate mode is captured on the first edge after reset release. A change of `half_rate_i` at any later time has no effect until the next reset.
- R7: The output word equals the input word plus STEP*STAGES*(STAGES+1)/2, modulo 2^WIDTH.
- R8: While `rst_ni` is low, and in the cycle after the first edge following its release, `out_valid_o` is 0.
- R9: An enabled input slot with `in_valid_i`=0 creates a bubble, and no output is produced for it.
- R10: Half-rate mode requires an even STAGES. An odd value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pipeline clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_rate_i | input | 1 | Rate select, sampled at the first edge after reset: 1 selects half rate |
| in_valid_i | input | 1 | Input word is valid |
| in_data_i | input | WIDTH | Input word |
| out_valid_o | output | 1 | Output word is new this cycle |
| out_data_o | output | WIDTH | Output word |

## Verification
The bench tracks the ring phase on its own. It then checks which offered words are taken: if the phase of the ring is off by one edge after reset, words offered on odd edges are taken instead of even ones and the output sequence shifts. The bench flips the rate select in the middle of a run. A design that does not lock the mode would start accepting on every edge or would break the alternation. In half-rate mode the bench watches for an output valid that lasts two cycles, which is what happens when the final stage's held valid flag is shown without tracking whether that stage just advanced. Bubbles in enabled slots check that an idle slot does not repeat the previous word.

// File: rtl/rot_en_pkg.sv
package rot_en_pkg;
  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;
endpackage

// File: rtl/enable_ring.sv
module enable_ring #(
  parameter int unsigned STAGES  = 4,
  parameter bit          HALF_OK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_rate_i,
  output logic [STAGES-1:0] en_o,
  output logic              half_o
);
  import rot_en_pkg::*;

  function automatic logic [STAGES-1:0] alt_seed();
    logic [STAGES-1:0] s;
    for (int i = 0; i < STAGES; i++) s[i] = (i % 2 == 0);
    return s;
  endfunction

  localparam logic [STAGES-1:0] SEED_HALF = alt_seed();
  localparam int unsigned HALF_POP = STAGES / 2;

  if (HALF_OK && (STAGES % 2 != 0)) begin : g_odd_stages_r10
    $error("half-rate needs an even stage count");
  end

  logic [STAGES-1:0] ring_q;
  logic              loaded_q;
  rate_e             rate_q;
  logic              pick_half;

  assign pick_half = HALF_OK && half_rate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q   <= '0;
      loaded_q <= 1'b0;
      rate_q   <= RATE_FULL;
    end else if (!loaded_q) begin
      ring_q   <= pick_half ? SEED_HALF : '1;
      loaded_q <= 1'b1;
      rate_q   <= pick_half ? RATE_HALF : RATE_FULL;
    end else begin
      ring_q <= {ring_q[STAGES-2:0], ring_q[STAGES-1]};
    end
  end

  assign en_o   = ring_q;
  assign half_o = (rate_q == RATE_HALF);

  p_ring_pop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |-> ($countones(ring_q) == (half_o ? HALF_POP : STAGES)));

  p_mode_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> $stable(rate_q));

  p_alt_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_o && ring_q[0]) |=> !ring_q[0]);
endmodule

// File: rtl/pipe_stage.sv
module pipe_stage #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned ADD   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  localparam logic [WIDTH-1:0] ADD_W = WIDTH'(ADD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      data_o  <= data_i + ADD_W;
    end
  end
endmodule

// File: rtl/rot_en_pipe.sv
module rot_en_pipe #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned STAGES  = 4,
  parameter int unsigned STEP    = 3,
  parameter bit          HALF_OK = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_rate_i,
  input  logic             in_valid_i,
  input  logic [WIDTH-1:0] in_data_i,
  output logic             out_valid_o,
  output logic [WIDTH-1:0] out_data_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] en;
  logic              half;
  logic [STAGES:0]   vld;
  logic [WIDTH-1:0]  dat [STAGES+1];
  logic              last_upd_q;

  enable_ring #(.STAGES(STAGES), .HALF_OK(HALF_OK)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_rate_i(half_rate_i),
    .en_o       (en),
    .half_o     (half)
  );

  assign vld[0] = in_valid_i;
  assign dat[0] = in_data_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    pipe_stage #(.WIDTH(WIDTH), .ADD(STEP * (i + 1))) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[i]),
      .valid_i(vld[i]),
      .data_i (dat[i]),
      .valid_o(vld[i+1]),
      .data_o (dat[i+1])
    );

    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en[i] |=> ($stable(dat[i+1]) && $stable(vld[i+1])));
  end

  // last stage advanced on the previous edge: its word is fresh
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_upd_q <= 1'b0;
    else         last_upd_q <= en[LAST];
  end

  assign out_valid_o = vld[STAGES] & last_upd_q;
  assign out_data_o  = dat[STAGES];

  p_no_b2b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half && out_valid_o) |=> !out_valid_o);

  p_full_flow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half && en[0] && in_valid_i) |=> vld[1]);
endmodule

// File: tb/rot_en_pipe_test.sv
module rot_en_pipe_test;
  localparam int W = 16;
  localparam int N = 4;
  localparam int STEP = 3;
  localparam logic [W-1:0] SUM = W'(STEP * N * (N + 1) / 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_rate = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;

  int total = 0;
  int bad = 0;
  int edge_no = -1;
  bit mode_half = 1'b0;
  bit prev_valid = 1'b0;
  logic [W-1:0] prev_data = '0;
  int due_q[$];
  logic [W-1:0] val_q[$];

  always #4 clk = ~clk;

  rot_en_pipe #(.WIDTH(W), .STAGES(N), .STEP(STEP), .HALF_OK(1'b1)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .half_rate_i(half_rate),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%0h expected=%0h", req, edge_no, act, exp);
    end
  endtask

  task automatic do_reset(input bit half);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    half_rate = half;
    due_q.delete();
    val_q.delete();
    @(negedge clk);
    check("R8", W'(out_valid), W'(0));
    @(negedge clk);
    rst_n = 1'b1;
    mode_half = half;
    edge_no = -1;
    prev_valid = 1'b0;
  endtask

  // one clock: drive at negedge, model, then check at the following negedge
  task automatic step(input bit v, input logic [W-1:0] d, input string req);
    int nxt;
    bit slot;
    bit exp_v;
    in_valid = v;
    in_data = d;
    nxt = edge_no + 1;
    slot = (nxt >= 1) && (!mode_half || (nxt % 2 == 1));
    if (slot && v) begin
      due_q.push_back(nxt + N - 1);
      val_q.push_back(d + SUM);
    end
    @(posedge clk);
    edge_no = nxt;
    @(negedge clk);
    exp_v = (due_q.size() > 0) && (due_q[0] == edge_no);
    check(req, W'(out_valid), W'(exp_v));
    if (exp_v) begin
      check("R7", out_data, val_q[0]);
      void'(due_q.pop_front());
      void'(val_q.pop_front());
    end
    if (mode_half) begin
      if (prev_valid) begin
        check("R4", W'(out_valid), W'(0));
        check("R5", out_data, prev_data);
      end
    end
    prev_valid = out_valid;
    prev_data = out_data;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 2 * N + 2; k++) step(1'b0, '0, req);
    check(req, W'(due_q.size()), W'(0));
  endtask

  initial begin
    // full rate, streaming
    do_reset(1'b0);
    step(1'b1, 16'h0101, "R8");
    for (int k = 0; k < 20; k++) step(1'b1, W'(k * 37 + 5), "R2");
    // bubbles in enabled slots
    for (int k = 0; k < 16; k++) step(k % 3 == 0, W'(k * 91), "R9");
    // mode flip mid-run must be ignored
    half_rate = 1'b1;
    for (int k = 0; k < 12; k++) step(1'b1, W'(16'hfff0 + k), "R6");
    drain("R2");

    // half rate, every edge offered
    do_reset(1'b1);
    for (int k = 0; k < 30; k++) step(1'b1, W'(k * 211 + 1), "R3");
    half_rate = 1'b0;
    for (int k = 0; k < 20; k++) step(1'b1, W'(k * 13), "R6");
    for (int k = 0; k < 16; k++) step(k % 4 < 2, W'(k + 16'h8000), "R9");
    drain("R3");

    // half rate, inputs only on the dropped slots
    do_reset(1'b1);
    for (int k = 0; k < 20; k++) step((edge_no + 1) % 2 == 0, W'(16'h4000 + k), "R3");
    drain("R1");

    // full rate after half, wraparound data
    do_reset(1'b0);
    for (int k = 0; k < 10; k++) step(1'b1, W'(16'hffff - k), "R1");
    drain("R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", edge_no, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule